// File: doc/BRIEF.md
# Synchronous Serial Burst Master

This block is a clock-driving master for a synchronous serial link. A single start command shifts a programmable run of 1 to 256 bits out of a 32-byte internal buffer onto a data-out line. During the same run it samples a data-in line and stores each received bit into the buffer position that the bit just sent came from. Before a run, software-side logic fills the buffer through a byte write port. After a run, it collects the received data through a byte read port.

Each bit is a low phase of the serial clock followed by a high phase, and each phase lasts a programmable number of system cycles. The output bit changes together with the falling clock edge, and the input bit is captured at the rising edge. The order of bits inside each byte can be least-significant first or most-significant first. A pause request freezes a run at the next whole-byte boundary, with the clock held high, until a resume command arrives.

Top module: `sio_burst_master`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), sclk=1, sdo=1, busy=0 and done=0.
- R2: A start (go=1 while idle) produces exactly bit_count_m1+1 serial clock pulses, so a value of 0 gives 1 bit and a value of 255 gives 256 bits.
- R3: Every low phase and every high phase of sclk lasts half_div+1 system cycles, for any half_div from 0 to 127.
- R4: Transfer bit i (counting from 0) comes from buffer byte i/8. Within that byte it is bit i%8 when msb_first=0 and bit 7-(i%8) when msb_first=1.
- R5: sdo changes only in the cycle in which sclk falls.
- R6: sdi is sampled at each rising edge of sclk. The sampled bit overwrites the buffer bit that was transmitted in that position, and all other buffer bits keep their values.
- R7: done is high for exactly one cycle per transfer, at the end of the final high phase, in the same cycle in which busy drops.
- R8: A pause request (pause_req pulse while busy) takes effect after the next bit whose index satisfies i%8==7. From then on sclk stays high, busy stays high and no pulse is produced until a resume pulse arrives; the transfer then continues with the next bit.
- R9: Writes on the byte write port are ignored while busy=1.
- R10: A go pulse while busy=1 is ignored and does not change the number of bits transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start pulse, accepted only while idle |
| msb_first | input | 1 | 1: bit 7 of each byte first; 0: bit 0 first |
| half_div | input | 7 | Phase length minus one, in system cycles |
| bit_count_m1 | input | 8 | Transfer length minus one, in bits |
| pause_req | input | 1 | Pulse: halt at the next byte boundary |
| resume | input | 1 | Pulse: continue a halted transfer |
| wr_en | input | 1 | Buffer byte write strobe |
| wr_addr | input | 5 | Buffer byte write address |
| wr_data | input | 8 | Buffer byte write data |
| rd_addr | input | 5 | Buffer byte read address |
| rd_data | output | 8 | Buffer byte at rd_addr (combinational) |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| busy | output | 1 | Transfer in progress or halted |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Several properties are checked on every cycle. sdo may move only with a falling sclk. A low clock or a halted state always implies busy. done is a single-cycle pulse that never overlaps busy. The phase counter counts down one step per cycle, the bit index stays within the programmed length, and the buffer never sees a byte write and a bit write in the same cycle. Some properties can only be shown by the bench's scenarios, because they relate a whole transfer to the buffer contents. These are the exact pulse count, the phase lengths, the mapping from bit index to buffer position in both orders, the in-place storage of received bits, the byte-aligned pause point, and the blocking of writes and restarts during a run.

// File: rtl/sio_burst_pkg.sv
// Package: shared state type and the bit-order helper used by the
// serial burst master. Assumes byte-organised storage (8 lanes).
package sio_burst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_HOLD = 2'd3
    } sio_state_e;

    // Map the position of a bit inside its byte to a physical lane.
    function automatic logic [2:0] lane_of(input logic [2:0] seq, input logic msb);
        return msb ? (3'd7 - seq) : seq;
    endfunction

endpackage

// File: rtl/sio_halfcnt.sv
// Module: down-counter that times one serial clock phase.
// A load sets the count; 'expired' is high while the count is zero.
// Assumes the controller reloads it at the start of every phase.
module sio_halfcnt #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    // Count down to zero, restarting on load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    assert_phase_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    assert_phase_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/sio_bitbuf.sv
// Module: byte-wide storage for the burst master. It has a byte write port,
// a byte read port, a single-bit read for transmit and a single-bit write
// for received data. Assumes the controller never issues both writes in one cycle.
module sio_bitbuf #(
    parameter int BYTES = 32,
    localparam int AW = $clog2(BYTES),
    localparam int BW = AW + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          bit_we,
    input  logic [BW-1:0] bit_addr,
    input  logic          bit_val,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    input  logic [BW-1:0] tx_addr,
    output logic          tx_bit
);

    logic [7:0] mem [BYTES];

    // Apply a byte write or a single received bit.
    always_ff @(posedge clk) begin
        for (int b = 0; b < BYTES; b++) begin
            if (!rst_n)
                mem[b] <= 8'h00;
            else if (wr_en && wr_addr == AW'(b))
                mem[b] <= wr_data;
            else if (bit_we && bit_addr[BW-1:3] == AW'(b))
                mem[b][bit_addr[2:0]] <= bit_val;
        end
    end

    assign rd_data = mem[rd_addr];
    assign tx_bit  = mem[tx_addr[BW-1:3]][tx_addr[2:0]];

    assert_no_dual_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && bit_we));

endmodule

// File: rtl/sio_burst_master.sv
// Module: synchronous serial master that moves 1..256 bits per start.
// The clock idles high; each bit is a low phase followed by a high phase.
// sdo changes as the clock falls, and sdi is captured as it rises into the
// buffer bit just transmitted. A pause halts at a byte boundary, clock high.
// Assumes go, pause_req and resume are single-cycle pulses synchronous to clk.
module sio_burst_master
    import sio_burst_pkg::*;
#(
    parameter int BUF_BYTES = 32,
    parameter int DIV_W     = 7,
    localparam int AW = $clog2(BUF_BYTES),
    localparam int CW = AW + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             msb_first,
    input  logic [DIV_W-1:0] half_div,
    input  logic [CW-1:0]    bit_count_m1,
    input  logic             pause_req,
    input  logic             resume,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [7:0]       rd_data,
    output logic             sclk,
    output logic             sdo,
    input  logic             sdi,
    output logic             busy,
    output logic             done
);

    sio_state_e       st;
    logic [CW-1:0]    idx, last_q;
    logic [DIV_W-1:0] div_q;
    logic             msb_q, pause_pend;
    logic             sclk_q, sdo_q, busy_q, done_q;

    logic             ph_load, ph_exp;
    logic [DIV_W-1:0] ph_val;
    logic [CW-1:0]    idx_nxt, cur_addr, nxt_addr, start_addr, tx_addr;
    logic             tx_bit, at_last, hold_now, bit_we, buf_wr;

    // Derived bit addresses for the current, next and first bit.
    always_comb begin
        idx_nxt    = idx + 1'b1;
        cur_addr   = {idx[CW-1:3], lane_of(idx[2:0], msb_q)};
        nxt_addr   = {idx_nxt[CW-1:3], lane_of(idx_nxt[2:0], msb_q)};
        start_addr = {{(CW-3){1'b0}}, lane_of(3'd0, msb_first)};
    end

    // Choose which buffer bit feeds sdo at the next falling edge.
    always_comb begin
        case (st)
            ST_IDLE: tx_addr = start_addr;
            ST_HOLD: tx_addr = cur_addr;
            default: tx_addr = nxt_addr;
        endcase
    end

    // Decide end-of-run, byte-boundary halt and phase-timer reload.
    always_comb begin
        at_last  = (idx == last_q);
        hold_now = (idx[2:0] == 3'd7) && (pause_pend || pause_req);
        ph_load  = (st == ST_IDLE && go)
                || (st == ST_LOW && ph_exp)
                || (st == ST_HIGH && ph_exp && !at_last && !hold_now)
                || (st == ST_HOLD && resume);
        ph_val   = (st == ST_IDLE) ? half_div : div_q;
        bit_we   = (st == ST_LOW) && ph_exp;
        buf_wr   = wr_en && !busy_q;
    end

    sio_halfcnt #(.W(DIV_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .expired  (ph_exp)
    );

    sio_bitbuf #(.BYTES(BUF_BYTES)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (buf_wr),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .bit_we   (bit_we),
        .bit_addr (cur_addr),
        .bit_val  (sdi),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .tx_addr  (tx_addr),
        .tx_bit   (tx_bit)
    );

    // Transfer sequencer: phases, bit index, pause and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            idx        <= '0;
            last_q     <= '0;
            div_q      <= '0;
            msb_q      <= 1'b0;
            pause_pend <= 1'b0;
            sclk_q     <= 1'b1;
            sdo_q      <= 1'b1;
            busy_q     <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (busy_q && pause_req)
                pause_pend <= 1'b1;
            case (st)
                ST_IDLE: begin
                    pause_pend <= 1'b0;
                    if (go) begin
                        last_q <= bit_count_m1;
                        div_q  <= half_div;
                        msb_q  <= msb_first;
                        idx    <= '0;
                        sclk_q <= 1'b0;
                        sdo_q  <= tx_bit;
                        busy_q <= 1'b1;
                        st     <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (ph_exp) begin
                        sclk_q <= 1'b1;
                        st     <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (ph_exp) begin
                        if (at_last) begin
                            busy_q     <= 1'b0;
                            done_q     <= 1'b1;
                            pause_pend <= 1'b0;
                            st         <= ST_IDLE;
                        end else begin
                            idx <= idx_nxt;
                            if (hold_now) begin
                                pause_pend <= 1'b0;
                                st         <= ST_HOLD;
                            end else begin
                                sclk_q <= 1'b0;
                                sdo_q  <= tx_bit;
                                st     <= ST_LOW;
                            end
                        end
                    end
                end
                ST_HOLD: begin
                    if (resume) begin
                        sclk_q <= 1'b0;
                        sdo_q  <= tx_bit;
                        st     <= ST_LOW;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign sclk = sclk_q;
    assign sdo  = sdo_q;
    assign busy = busy_q;
    assign done = done_q;

    assert_sdo_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(sclk_q) |-> $stable(sdo_q));

    assert_low_means_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_q |-> busy_q);

    assert_index_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (idx <= last_q));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!busy_q && $past(busy_q)));

    assert_hold_clock_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |-> (sclk_q && busy_q && idx[2:0] == 3'd0));

    assert_restart_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !done_q && $past(busy_q)) |-> $stable(last_q));

endmodule

// File: tb/sio_burst_master_tb.sv
// Bench: a vector table of (order, phase length, bit count) is run through
// a serial slave model. Directed tests then cover reset, pause/resume and
// blocked writes and restarts.
module sio_burst_master_tb;

    localparam int BYTES = 32;
    localparam int NV    = 6;
    // {msb_first, half_div[6:0], bit_count_m1[7:0]}
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 7'd0,   8'd7},
        {1'b1, 7'd1,   8'd15},
        {1'b0, 7'd2,   8'd0},
        {1'b1, 7'd0,   8'd255},
        {1'b0, 7'd3,   8'd11},
        {1'b1, 7'd127, 8'd2}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go = 1'b0, msb_first = 1'b0, pause_req = 1'b0, resume = 1'b0;
    logic [6:0] half_div = '0;
    logic [7:0] bit_count_m1 = '0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0, rd_data;
    logic       sclk, sdo, sdi, busy, done;

    int  n_chk = 0, n_bad = 0;
    int  seed_g = 0;
    int  edge_cnt = 0, low_cnt = 0, done_cnt = 0;
    logic mon_en = 1'b0;
    logic [7:0] model [BYTES];
    logic       tx_log [256];

    always #10 clk = ~clk;

    sio_burst_master u_dut (
        .clk(clk), .rst_n(rst_n), .go(go), .msb_first(msb_first),
        .half_div(half_div), .bit_count_m1(bit_count_m1),
        .pause_req(pause_req), .resume(resume),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .sclk(sclk), .sdo(sdo), .sdi(sdi), .busy(busy), .done(done)
    );

    function automatic logic rx_pat(input int i, input int s);
        return ((i * 7 + s) % 5) < 2;
    endfunction

    assign sdi = rx_pat(edge_cnt, seed_g);

    // Slave model: log sdo and advance the bit count at each rising sclk.
    always @(posedge sclk) begin
        if (mon_en) begin
            if (edge_cnt < 256) tx_log[edge_cnt] = sdo;
            edge_cnt = edge_cnt + 1;
        end
    end

    // Count low-clock cycles and done pulses.
    always @(posedge clk) begin
        if (mon_en && !sclk) low_cnt = low_cnt + 1;
        if (mon_en && done)  done_cnt = done_cnt + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic fill(input int s);
        for (int k = 0; k < BYTES; k++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 5'(k); wr_data = 8'((k * 37 + s * 11) & 8'hFF);
            model[k] = wr_data;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic launch(input logic m, input logic [6:0] d, input logic [7:0] c, input int s);
        @(negedge clk);
        seed_g = s; edge_cnt = 0; low_cnt = 0; done_cnt = 0; mon_en = 1'b1;
        msb_first = m; half_div = d; bit_count_m1 = c; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 100000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 100000) chk(1'b0, "watchdog", guard, 0);
        repeat (2) @(negedge clk);
        mon_en = 1'b0;
    endtask

    task automatic verify_run(input logic m, input int n, input int s, input string tg);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            int lane = m ? 7 - (i % 8) : i % 8;
            if (tx_log[i] !== model[i / 8][lane]) bad++;
            model[i / 8][lane] = rx_pat(i, s);
        end
        chk(bad == 0, {tg, " R4 R5 tx order"}, bad, 0);
        bad = 0;
        for (int k = 0; k < BYTES; k++) begin
            rd_addr = 5'(k);
            #1;
            if (rd_data !== model[k]) bad++;
        end
        chk(bad == 0, {tg, " R6 rx stored"}, bad, 0);
    endtask

    initial begin
        #(20 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(sclk === 1'b1 && sdo === 1'b1, "R1 reset lines", {sclk, sdo}, 3);
        chk(busy === 1'b0 && done === 1'b0, "R1 reset flags", {busy, done}, 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            logic m; logic [6:0] d; logic [7:0] c; int n;
            {m, d, c} = VEC[v];
            n = int'(c) + 1;
            fill(v + 1);
            launch(m, d, c, v + 3);
            wait_idle();
            chk(edge_cnt == n, "R2 pulse count", edge_cnt, n);
            chk(low_cnt == n * (int'(d) + 1), "R3 low cycles", low_cnt, n * (int'(d) + 1));
            chk(done_cnt == 1, "R7 done pulses", done_cnt, 1);
            verify_run(m, n, v + 3, "vec");
        end

        // Pause at a byte boundary, with a blocked write and restart while halted.
        fill(9);
        launch(1'b0, 7'd1, 8'd23, 5);
        @(negedge clk);
        pause_req = 1'b1;
        @(negedge clk);
        pause_req = 1'b0;
        repeat (200) @(negedge clk);
        chk(edge_cnt == 8, "R8 halt after byte", edge_cnt, 8);
        chk(sclk === 1'b1 && busy === 1'b1, "R8 clock high busy", {sclk, busy}, 3);
        wr_en = 1'b1; wr_addr = 5'd2; wr_data = 8'hA5; go = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; go = 1'b0;
        repeat (20) @(negedge clk);
        chk(edge_cnt == 8, "R8 no pulses while halted", edge_cnt, 8);
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
        wait_idle();
        chk(edge_cnt == 24, "R10 length kept", edge_cnt, 24);
        chk(done_cnt == 1, "R7 done after resume", done_cnt, 1);
        verify_run(1'b0, 24, 5, "pause R9");

        // Write and restart during an active shift (not halted).
        fill(4);
        launch(1'b1, 7'd2, 8'd39, 7);
        repeat (10) @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd20; wr_data = 8'h3C; go = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; go = 1'b0;
        wait_idle();
        chk(edge_cnt == 40, "R10 restart ignored", edge_cnt, 40);
        rd_addr = 5'd20;
        #1;
        chk(rd_data === model[20], "R9 write ignored", rd_data, model[20]);
        verify_run(1'b1, 40, 7, "busy");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule